// File: doc/BRIEF.md
# Round-Robin Interleaved Multiplier Array

This block raises the rate of a slow multiplier by replicating it instead of pipelining it. Several identical multiply units sit behind one valid-qualified operand input. Each accepted operand pair is steered to the next unit in a fixed rotation. That unit holds the pair and spends several cycles producing the product. A rotating output select then gathers the finished products back onto a single valid-qualified result port.

With `LANES` units, each unit is occupied for `LANES - 1` cycles. The output register adds one more cycle, so the array can take a new pair on every clock. Each product appears exactly `LANES` cycles after its operands. Results leave in the order their operands arrived, and idle input cycles leave matching idle output cycles. The block has no back-pressure. A producer may present a pair on any cycle, and the consumer must take every result in the cycle it is valid.

Top module: `rr_mult_array`

## Requirements
- R1: While `rst` is high at a clock edge, `out_valid` and `out_prod` are driven to zero and both rotation pointers return to unit 0.
- R2: A pair sampled with `in_valid` high in cycle c yields `out_valid` high in cycle c+LANES, with `out_prod` equal to the unsigned product `in_a*in_b` at full 2*WIDTH width.
- R3: `out_valid` is low in every cycle c+LANES for which `in_valid` was low in cycle c.
- R4: Products are presented strictly in arrival order. With `in_valid` held high on consecutive cycles, a product is presented on every consecutive cycle.
- R5: Accepted pairs go to units 0, 1, …, LANES-1 and then back to 0. The load pointer advances only on cycles with `in_valid` high, so gaps of any length keep ordering intact.
- R6: A unit is never loaded while it is still working on an earlier pair.
- R7: At most one unit completes in any cycle, and the completing unit is always the one the output select points at.
- R8: When `out_valid` is low, `out_prod` keeps the last presented product. Values on `in_a` and `in_b` in cycles with `in_valid` low have no effect on any later output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Operand pair present this cycle |
| in_a | input | WIDTH | First operand, unsigned |
| in_b | input | WIDTH | Second operand, unsigned |
| out_valid | output | 1 | Product present this cycle |
| out_prod | output | 2*WIDTH | Product, unsigned |

## Verification
The bench builds the array with four units and 4-bit operands. At that size every one of the 256 operand pairs can be streamed back to back, so every product value and every unit-to-output rotation phase gets covered. The bench then drives pairs with random gaps and with garbage operands on idle cycles. This makes the load and select pointers wrap at uneven offsets and exercises the hold behaviour of the result port. Corner pairs with all-ones and zero operands, plus an alternating on/off pattern, close the run.

// File: rtl/rr_pkg.sv
package rr_pkg;

  // Next position of a rotating pointer over n slots.
  function automatic int unsigned rot_next(int unsigned cur, int unsigned n);
    return (cur + 1 >= n) ? 0 : cur + 1;
  endfunction

endpackage

// File: rtl/rr_issue_ctrl.sv
module rr_issue_ctrl #(
  parameter int LANES = 4,
  parameter int PTR_W = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             in_valid,
  output logic [LANES-1:0] load_en,
  output logic [PTR_W-1:0] load_ptr
);

  always_ff @(posedge clk) begin
    if (rst) begin
      load_ptr <= '0;
    end else if (in_valid) begin
      load_ptr <= PTR_W'(rr_pkg::rot_next(32'(load_ptr), LANES));
    end
  end

  for (genvar i = 0; i < LANES; i++) begin : g_en
    assign load_en[i] = in_valid && (load_ptr == PTR_W'(i));
  end

  // R5: an accepted pair always loads exactly one unit; an idle cycle loads none.
  a_r5_one_load: assert property (@(posedge clk) disable iff (rst)
    in_valid |-> $countones(load_en) == 1);
  a_r5_idle_hold: assert property (@(posedge clk) disable iff (rst)
    !in_valid |=> $stable(load_ptr));

endmodule

// File: rtl/rr_mul_unit.sv
module rr_mul_unit #(
  parameter int WIDTH = 8,
  parameter int CYC   = 3
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               load,
  input  logic [WIDTH-1:0]   a,
  input  logic [WIDTH-1:0]   b,
  output logic               busy,
  output logic               done,
  output logic [2*WIDTH-1:0] prod
);

  localparam int CNT_W = $clog2(CYC + 1);
  localparam int PW    = 2 * WIDTH;

  logic [WIDTH-1:0] a_q, b_q;
  logic [CNT_W-1:0] stage;
  logic             finish;

  assign finish = busy && (stage == CNT_W'(CYC - 1));

  always_ff @(posedge clk) begin
    if (rst) begin
      busy  <= 1'b0;
      done  <= 1'b0;
      stage <= '0;
    end else begin
      done <= finish;
      if (load) begin
        busy  <= 1'b1;
        stage <= CNT_W'(1);
      end else if (finish) begin
        busy  <= 1'b0;
      end else if (busy) begin
        stage <= stage + CNT_W'(1);
      end
    end
  end

  // Operand and result storage without reset.
  always_ff @(posedge clk) begin
    if (load) begin
      a_q <= a;
      b_q <= b;
    end
    if (finish) begin
      prod <= PW'(a_q) * PW'(b_q);
    end
  end

  // R6: a unit is only loaded when idle.
  a_r6_load_idle: assert property (@(posedge clk) disable iff (rst)
    load |-> !busy);
  // R2: completion follows a busy period.
  a_r2_done_after_busy: assert property (@(posedge clk) disable iff (rst)
    done |-> $past(busy));

endmodule

// File: rtl/rr_result_mux.sv
module rr_result_mux #(
  parameter int LANES = 4,
  parameter int PW    = 16,
  parameter int PTR_W = 2
) (
  input  logic                      clk,
  input  logic                      rst,
  input  logic [LANES-1:0]          done,
  input  logic [LANES-1:0][PW-1:0]  prod,
  output logic                      out_valid,
  output logic [PW-1:0]             out_prod
);

  logic [PTR_W-1:0] sel;
  logic             any_done;

  assign any_done = |done;

  always_ff @(posedge clk) begin
    if (rst) begin
      sel       <= '0;
      out_valid <= 1'b0;
      out_prod  <= '0;
    end else begin
      out_valid <= any_done;
      if (any_done) begin
        out_prod <= prod[sel];
        sel      <= PTR_W'(rr_pkg::rot_next(32'(sel), LANES));
      end
    end
  end

  // R7: one completion per cycle, and it is the unit under the select.
  a_r7_single_done: assert property (@(posedge clk) disable iff (rst)
    $onehot0(done));
  a_r7_sel_match: assert property (@(posedge clk) disable iff (rst)
    any_done |-> done[sel]);
  // R8: the result port holds when nothing completes.
  a_r8_hold: assert property (@(posedge clk) disable iff (rst)
    !out_valid |-> $stable(out_prod) || $past(rst));

endmodule

// File: rtl/rr_mult_array.sv
module rr_mult_array #(
  parameter int LANES = 4,
  parameter int WIDTH = 8
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               in_valid,
  input  logic [WIDTH-1:0]   in_a,
  input  logic [WIDTH-1:0]   in_b,
  output logic               out_valid,
  output logic [2*WIDTH-1:0] out_prod
);

  localparam int PTR_W    = (LANES > 1) ? $clog2(LANES) : 1;
  localparam int PW       = 2 * WIDTH;
  localparam int UNIT_CYC = LANES - 1;

  logic [LANES-1:0]         load_en;
  logic [PTR_W-1:0]         load_ptr;
  logic [LANES-1:0]         busy;
  logic [LANES-1:0]         done;
  logic [LANES-1:0][PW-1:0] prod;

  rr_issue_ctrl #(.LANES(LANES), .PTR_W(PTR_W)) u_issue (
    .clk      (clk),
    .rst      (rst),
    .in_valid (in_valid),
    .load_en  (load_en),
    .load_ptr (load_ptr)
  );

  for (genvar i = 0; i < LANES; i++) begin : g_unit
    rr_mul_unit #(.WIDTH(WIDTH), .CYC(UNIT_CYC)) u_mul (
      .clk  (clk),
      .rst  (rst),
      .load (load_en[i]),
      .a    (in_a),
      .b    (in_b),
      .busy (busy[i]),
      .done (done[i]),
      .prod (prod[i])
    );
  end

  rr_result_mux #(.LANES(LANES), .PW(PW), .PTR_W(PTR_W)) u_mux (
    .clk       (clk),
    .rst       (rst),
    .done      (done),
    .prod      (prod),
    .out_valid (out_valid),
    .out_prod  (out_prod)
  );

  // R3: a valid result always stems from a unit completion one cycle before.
  a_r3_no_phantom: assert property (@(posedge clk) disable iff (rst)
    out_valid |-> $past(|done));
  // R1: the first cycle after reset presents nothing.
  a_r1_reset_quiet: assert property (@(posedge clk)
    $past(rst) |-> !out_valid);

endmodule

// File: tb/rr_mult_array_tb.sv
module rr_mult_array_tb;

  localparam int LANES = 4;
  localparam int W     = 4;
  localparam int PW    = 2 * W;

  logic          clk = 1'b0;
  logic          rst;
  logic          in_valid;
  logic [W-1:0]  in_a, in_b;
  logic          out_valid;
  logic [PW-1:0] out_prod;

  int n_checks = 0;
  int n_fail   = 0;
  int cyc      = 0;
  bit finished = 0;

  logic          exp_v [8];
  logic [PW-1:0] exp_p [8];
  string         exp_t [8];
  logic [PW-1:0] last_p;

  always #10 clk = ~clk;

  rr_mult_array #(.LANES(LANES), .WIDTH(W)) u_dut (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_a(in_a), .in_b(in_b),
    .out_valid(out_valid), .out_prod(out_prod)
  );

  task automatic check(input bit ok, input string tag, input logic [PW:0] act, input logic [PW:0] expv);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s cycle %0d: actual %0h expected %0h", tag, cyc, act, expv);
    end
  endtask

  // One cycle: check the output due now, then drive the next input.
  task automatic step(input bit v, input logic [W-1:0] a, input logic [W-1:0] b, input string tag);
    int old;
    @(negedge clk);
    old = (cyc + 8 - LANES) % 8;
    if (exp_v[old]) begin
      check(out_valid === 1'b1, {exp_t[old], " valid"}, {PW'(0), out_valid}, 1);
      check(out_prod === exp_p[old], {exp_t[old], " product"}, {1'b0, out_prod}, {1'b0, exp_p[old]});
      last_p = exp_p[old];
    end else begin
      check(out_valid === 1'b0, "R3 idle", {PW'(0), out_valid}, 0);
      check(out_prod === last_p, "R8 hold", {1'b0, out_prod}, {1'b0, last_p});
    end
    in_valid = v;
    in_a     = a;
    in_b     = b;
    exp_v[cyc % 8] = v;
    exp_p[cyc % 8] = PW'(a) * PW'(b);
    exp_t[cyc % 8] = tag;
    cyc++;
  endtask

  initial begin
    rst = 1'b1; in_valid = 1'b0; in_a = '0; in_b = '0; last_p = '0;
    for (int i = 0; i < 8; i++) begin exp_v[i] = 1'b0; exp_p[i] = '0; exp_t[i] = ""; end
    repeat (3) @(negedge clk);
    // R1: reset state.
    check(out_valid === 1'b0, "R1 valid", {PW'(0), out_valid}, 0);
    check(out_prod === '0, "R1 product", {1'b0, out_prod}, 0);
    rst = 1'b0;
    // R2 R4 R6: exhaustive back-to-back sweep.
    for (int x = 0; x < (1 << W); x++)
      for (int y = 0; y < (1 << W); y++)
        step(1'b1, W'(x), W'(y), "R2 R4 R6 sweep");
    // R5 R7 R8: random gaps with garbage operands on idle cycles.
    for (int k = 0; k < 300; k++) begin
      if ($urandom_range(1, 0) == 1)
        step(1'b1, W'($urandom), W'($urandom), "R5 R7 gapped");
      else
        step(1'b0, W'($urandom), W'($urandom), "R8 idle");
    end
    // Corner operands and an alternating pattern.
    step(1'b1, '1, '1, "R2 max");
    step(1'b1, '0, '1, "R2 zero");
    step(1'b1, '1, '0, "R2 zero");
    for (int k = 0; k < 16; k++)
      step(k[0], W'(k), W'(15 - k), "R4 R5 alternate");
    for (int k = 0; k < 2 * LANES; k++) step(1'b0, '1, '1, "R3 drain");
    finished = 1;
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      n_checks++;
      n_fail++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
    end
  end

endmodule